// File: doc/BRIEF.md
# STUMPS Logic Self-Test Engine

This block runs a complete logic self-test without any stimulus from outside. A seeded 16-bit XOR-feedback shift register produces pseudo-random bits. Each clock it feeds one bit into each of four scan chains of a small built-in circuit under test. After a full chain load, a single capture clock stores the circuit's responses back into the chains. While the next pattern is shifted in, those responses leave the chains and are folded into a 16-bit multiple-input signature register. Once the requested number of patterns has run and the last responses have been shifted out, the signature is compared with a golden value. The block then raises a done flag together with a pass or fail result.

A user supplies a seed, a pattern count and a golden signature, and pulses start. All three values are captured when the start is accepted. The result stays visible until the next accepted start. Two test inputs force one capture bit of the circuit to zero. This models a stuck-at-0 defect, so that a run with a defect can be compared against a clean run.

Top module: `lbist_engine`

## Requirements
- R1: After reset, busy_o, done_o and pass_o are 0 and signature_o is 0.
- R2: The pattern generator is a 16-bit shift-left register. Its new bit 0 is the XOR of bits 15, 13, 12 and 10 (polynomial x^16+x^14+x^13+x^11+1). It advances once per load shift clock. A seed of zero is replaced by 16'hACE1. Chain c receives generator bit 4c+3 on each shift clock.
- R3: There are four chains of eight flops. Flat flop index i = 8c+j, where j is the position in chain c. On a shift clock each chain moves toward j=7, bit j=0 takes the serial input, and bit j=7 is the scan output. All chain flops are cleared when a start is accepted.
- R4: On a capture clock, every flop i takes x[(i+7)%32] XOR (x[(i+1)%32] AND NOT x[(i+13)%32]), using the flop values x from before the clock.
- R5: The signature register is cleared when a start is accepted. On every shift clock (load or final unload) it becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}, XORed with the four chain scan outputs on bits 3..0 (chain c on bit c). signature_o shows this register.
- R6: If a start is accepted at clock edge k with pattern count N, the block performs N rounds of 8 shift clocks followed by 1 capture clock. It then performs 8 unload shift clocks, during which the generator holds. done_o becomes 1 right after edge k+9N+9.
- R7: When done_o rises, pass_o is 1 exactly when signature_o equals the golden value latched at start. done_o, pass_o and signature_o then stay unchanged until the next accepted start. busy_o is 1 from the accepting edge until done_o rises, and busy_o and done_o are never both 1.
- R8: A start pulse while busy_o is 1 has no effect: the running test finishes with its own latency and signature.
- R9: A pattern count of 0 runs only the final unload of the cleared chains. The result is signature 0, with done after edge k+9.
- R10: While fault_en_i is 1, a capture clock writes 0 into flop fault_idx_i instead of its computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| seed_i | input | 16 | Generator seed, latched at start |
| pat_count_i | input | 16 | Number of patterns, latched at start |
| golden_i | input | 16 | Expected signature, latched at start |
| fault_en_i | input | 1 | Enables the injected stuck-at-0 on capture |
| fault_idx_i | input | 5 | Flat flop index forced to 0 on capture |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished, held until next start |
| pass_o | output | 1 | Signature matched golden value |
| signature_o | output | 16 | Current signature register |

## Verification
The bench builds the engine with its default values: a 16-bit generator and signature, four chains of eight flops, and a 16-bit pattern count. This keeps a full run within a few hundred clocks, so counts from 0 to 40 can be checked against a bench model of the whole scan path, and the exact completion latency can be checked on every run. Because the circuit has only 32 flops, any of its fault sites can be chosen at random. With a zero seed and a zero count, the default-seed substitution and the unload-only path are both reached.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SHIFT   = 3'd1,
        ST_CAPTURE = 3'd2,
        ST_UNLOAD  = 3'd3,
        ST_COMPARE = 3'd4
    } lbist_state_e;

    localparam logic [15:0] LBIST_DEFAULT_SEED = 16'hACE1;
    localparam logic [15:0] LBIST_TAPS         = 16'hB400;

endpackage

// File: rtl/lbist_prpg.sv
module lbist_prpg #(
    parameter int               WIDTH        = 16,
    parameter logic [WIDTH-1:0] TAPS         = 16'hB400,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] state_o
);

    typedef struct packed {
        logic [WIDTH-1:0] lfsr;
    } prpg_reg_t;

    prpg_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.lfsr = (seed_i == '0) ? DEFAULT_SEED : seed_i;
        end else if (step_i) begin
            r_d.lfsr = {r_q.lfsr[WIDTH-2:0], ^(r_q.lfsr & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.lfsr <= DEFAULT_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.lfsr;

    // R2: an all-zero state would lock the generator
    assert_prpg_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.lfsr != '0);

    // R2: a step shifts the register left by one
    assert_prpg_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> r_q.lfsr[WIDTH-1:1] == $past(r_q.lfsr[WIDTH-2:0]));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
    parameter int               WIDTH = 16,
    parameter int               N_IN  = 4,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [N_IN-1:0]  data_i,
    output logic [WIDTH-1:0] sig_o
);

    localparam int PAD_W = WIDTH - N_IN;

    typedef struct packed {
        logic [WIDTH-1:0] sig;
    } misr_reg_t;

    misr_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.sig = '0;
        end else if (step_i) begin
            r_d.sig = {r_q.sig[WIDTH-2:0], ^(r_q.sig & TAPS)} ^ {{PAD_W{1'b0}}, data_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sig <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sig_o = r_q.sig;

    // R5: clearing at start empties the signature
    assert_misr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> sig_o == '0);

    // R5: without a step or clear the signature holds
    assert_misr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !step_i) |=> $stable(sig_o));

endmodule

// File: rtl/lbist_scan_cut.sv
module lbist_scan_cut #(
    parameter int N_CHAINS  = 4,
    parameter int CHAIN_LEN = 8,
    localparam int N_FLOPS  = N_CHAINS * CHAIN_LEN,
    localparam int IDX_W    = $clog2(N_FLOPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                shift_i,
    input  logic                capture_i,
    input  logic [N_CHAINS-1:0] scan_in_i,
    output logic [N_CHAINS-1:0] scan_out_o,
    input  logic                fault_en_i,
    input  logic [IDX_W-1:0]    fault_idx_i
);

    typedef struct packed {
        logic [N_FLOPS-1:0] flops;
    } cut_reg_t;

    cut_reg_t r_d, r_q;
    logic [N_FLOPS-1:0] resp;
    logic [N_FLOPS-1:0] shifted;

    // combinational circuit under test between the chain flops
    always_comb begin
        for (int i = 0; i < N_FLOPS; i++) begin
            resp[i] = r_q.flops[(i + 7) % N_FLOPS]
                    ^ (r_q.flops[(i + 1) % N_FLOPS] & ~r_q.flops[(i + 13) % N_FLOPS]);
            if (fault_en_i && (fault_idx_i == IDX_W'(i))) begin
                resp[i] = 1'b0;
            end
        end
    end

    for (genvar c = 0; c < N_CHAINS; c++) begin : g_chain
        assign shifted[c*CHAIN_LEN +: CHAIN_LEN] =
            {r_q.flops[c*CHAIN_LEN +: CHAIN_LEN-1], scan_in_i[c]};
        assign scan_out_o[c] = r_q.flops[c*CHAIN_LEN + CHAIN_LEN - 1];
    end

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.flops = '0;
        end else if (shift_i) begin
            r_d.flops = shifted;
        end else if (capture_i) begin
            r_d.flops = resp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.flops <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R10: the injected site reads zero after a capture
    assert_fault_site_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && !clear_i && !shift_i && fault_en_i) |=> r_q.flops[$past(fault_idx_i)] == 1'b0);

    // R3: chain 0 serial input lands in its first flop
    assert_scan_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clear_i) |=> r_q.flops[0] == $past(scan_in_i[0]));

endmodule

// File: rtl/lbist_engine.sv
module lbist_engine
    import lbist_pkg::*;
#(
    parameter int               WIDTH        = 16,
    parameter int               N_CHAINS     = 4,
    parameter int               CHAIN_LEN    = 8,
    parameter int               CNT_W        = 16,
    parameter logic [WIDTH-1:0] TAPS         = LBIST_TAPS,
    parameter logic [WIDTH-1:0] DEFAULT_SEED = LBIST_DEFAULT_SEED,
    localparam int              FAULT_W      = $clog2(N_CHAINS * CHAIN_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [WIDTH-1:0]   seed_i,
    input  logic [CNT_W-1:0]   pat_count_i,
    input  logic [WIDTH-1:0]   golden_i,
    input  logic               fault_en_i,
    input  logic [FAULT_W-1:0] fault_idx_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               pass_o,
    output logic [WIDTH-1:0]   signature_o
);

    localparam int                 BIT_W    = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
    localparam int                 STRIDE   = WIDTH / N_CHAINS;
    localparam logic [BIT_W-1:0]   LAST_BIT = BIT_W'(CHAIN_LEN - 1);

    typedef struct packed {
        lbist_state_e       state;
        logic [CNT_W-1:0]   pats;
        logic [BIT_W-1:0]   bits;
        logic [WIDTH-1:0]   golden;
        logic               done;
        logic               pass;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                accept;
    logic                scan_shift;
    logic                prpg_step;
    logic                capture;
    logic [WIDTH-1:0]    prpg_state;
    logic [WIDTH-1:0]    sig;
    logic [N_CHAINS-1:0] chain_in;
    logic [N_CHAINS-1:0] chain_out;

    assign accept     = start_i && (c_q.state == ST_IDLE);
    assign prpg_step  = (c_q.state == ST_SHIFT);
    assign scan_shift = (c_q.state == ST_SHIFT) || (c_q.state == ST_UNLOAD);
    assign capture    = (c_q.state == ST_CAPTURE);

    for (genvar c = 0; c < N_CHAINS; c++) begin : g_tap
        assign chain_in[c] = prpg_state[c*STRIDE + STRIDE - 1];
    end

    lbist_prpg #(
        .WIDTH        (WIDTH),
        .TAPS         (TAPS),
        .DEFAULT_SEED (DEFAULT_SEED)
    ) i_prpg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .seed_i  (seed_i),
        .step_i  (prpg_step),
        .state_o (prpg_state)
    );

    lbist_scan_cut #(
        .N_CHAINS  (N_CHAINS),
        .CHAIN_LEN (CHAIN_LEN)
    ) i_cut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (accept),
        .shift_i     (scan_shift),
        .capture_i   (capture),
        .scan_in_i   (chain_in),
        .scan_out_o  (chain_out),
        .fault_en_i  (fault_en_i),
        .fault_idx_i (fault_idx_i)
    );

    lbist_misr #(
        .WIDTH (WIDTH),
        .N_IN  (N_CHAINS),
        .TAPS  (TAPS)
    ) i_misr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (scan_shift),
        .data_i  (chain_out),
        .sig_o   (sig)
    );

    // sequencer: shift, capture, final unload, compare
    always_comb begin
        c_d = c_q;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.golden = golden_i;
                    c_d.pats   = pat_count_i;
                    c_d.bits   = '0;
                    c_d.done   = 1'b0;
                    c_d.pass   = 1'b0;
                    c_d.state  = (pat_count_i == '0) ? ST_UNLOAD : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                c_d.bits = c_q.bits + 1'b1;
                if (c_q.bits == LAST_BIT) begin
                    c_d.bits  = '0;
                    c_d.state = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                c_d.pats  = c_q.pats - 1'b1;
                c_d.state = (c_q.pats == CNT_W'(1)) ? ST_UNLOAD : ST_SHIFT;
            end
            ST_UNLOAD: begin
                c_d.bits = c_q.bits + 1'b1;
                if (c_q.bits == LAST_BIT) begin
                    c_d.bits  = '0;
                    c_d.state = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                c_d.done  = 1'b1;
                c_d.pass  = (sig == c_q.golden);
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state  <= ST_IDLE;
            c_q.pats   <= '0;
            c_q.bits   <= '0;
            c_q.golden <= '0;
            c_q.done   <= 1'b0;
            c_q.pass   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o      = (c_q.state != ST_IDLE);
    assign done_o      = c_q.done;
    assign pass_o      = c_q.pass;
    assign signature_o = sig;

    // R7: result held until the next accepted start
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o && $stable(pass_o) && $stable(signature_o));

    // R7: busy and done never overlap
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    // R7: verdict agrees with the signature seen at completion
    assert_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (pass_o == (signature_o == c_q.golden)));

    // R8: a start while busy leaves the latched golden value alone
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(c_q.golden));

    // R6: capture lasts exactly one clock
    assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !capture);

endmodule

// File: tb/test_lbist_engine.sv
module test_lbist_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] seed_i = '0;
    logic [15:0] pat_count_i = '0;
    logic [15:0] golden_i = '0;
    logic        fault_en_i = 1'b0;
    logic [4:0]  fault_idx_i = '0;
    logic        busy_o, done_o, pass_o;
    logic [15:0] signature_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    lbist_engine i_lbist_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .seed_i      (seed_i),
        .pat_count_i (pat_count_i),
        .golden_i    (golden_i),
        .fault_en_i  (fault_en_i),
        .fault_idx_i (fault_idx_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .signature_o (signature_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected signature from R2..R5, R9, R10
    function automatic logic [15:0] model_sig(input logic [15:0] seed, input int n,
                                              input bit fe, input int fi);
        logic [15:0] p, m;
        logic [31:0] x, nx, y;
        logic [3:0]  so;
        p = (seed == 16'h0) ? 16'hACE1 : seed;
        m = '0;
        x = '0;
        for (int pat = 0; pat <= n; pat++) begin
            for (int k = 0; k < 8; k++) begin
                for (int c = 0; c < 4; c++) begin
                    so[c] = x[8*c+7];
                    nx[8*c +: 8] = {x[8*c +: 7], p[4*c+3]};
                end
                m = {m[14:0], m[15] ^ m[13] ^ m[12] ^ m[10]} ^ {12'h0, so};
                x = nx;
                if (pat < n) p = {p[14:0], p[15] ^ p[13] ^ p[12] ^ p[10]};
            end
            if (pat < n) begin
                for (int i = 0; i < 32; i++) begin
                    y[i] = x[(i+7)%32] ^ (x[(i+1)%32] & ~x[(i+13)%32]);
                    if (fe && fi == i) y[i] = 1'b0;
                end
                x = y;
            end
        end
        return m;
    endfunction

    // one full run; ignored_at > 0 pulses a second start that many cycles in (R8)
    task automatic run(input logic [15:0] seed, input int n, input logic [15:0] gold,
                       input bit fe, input int fi, input int ignored_at);
        logic [15:0] exp_sig;
        int cyc;
        exp_sig = model_sig(seed, n, fe, fi);
        @(negedge clk);
        seed_i = seed; pat_count_i = 16'(n); golden_i = gold;
        fault_en_i = fe; fault_idx_i = 5'(fi);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seed_i = ~seed; golden_i = ~gold; pat_count_i = 16'(n + 3);
        check("R7 busy after start", {31'b0, busy_o}, 32'd1);
        check("R7 done cleared at start", {31'b0, done_o}, 32'd0);
        cyc = 1;
        while (!done_o && cyc < 2000) begin
            if (ignored_at > 0 && cyc == ignored_at) start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        check(ignored_at > 0 ? "R8 latency with ignored start" : "R6 latency",
              cyc, 9 * n + 10);
        check(n == 0 ? "R9 signature" : (fe ? "R10 signature" : "R5 signature"),
              {16'b0, signature_o}, {16'b0, exp_sig});
        check("R7 pass verdict", {31'b0, pass_o}, {31'b0, exp_sig == gold});
        check("R7 busy low at done", {31'b0, busy_o}, 32'd0);
        repeat (($urandom % 5) + 2) @(negedge clk);
        check("R7 done held", {31'b0, done_o}, 32'd1);
        check("R7 signature held", {16'b0, signature_o}, {16'b0, exp_sig});
        check("R7 pass held", {31'b0, pass_o}, {31'b0, exp_sig == gold});
        fault_en_i = 1'b0;
    endtask

    initial begin
        logic [15:0] clean, faulty;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 busy reset", {31'b0, busy_o}, 32'd0);
        check("R1 done reset", {31'b0, done_o}, 32'd0);
        check("R1 pass reset", {31'b0, pass_o}, 32'd0);
        check("R1 signature reset", {16'b0, signature_o}, 32'd0);
        rst_n = 1'b1;

        // R9: zero count
        run(16'h1234, 0, 16'h0000, 1'b0, 0, 0);
        // R2: zero seed takes the default value
        run(16'h0000, 3, model_sig(16'hACE1, 3, 1'b0, 0), 1'b0, 0, 0);
        // R4/R5: single pattern, and a failing golden value
        run(16'hFFFF, 1, model_sig(16'hFFFF, 1, 1'b0, 0), 1'b0, 0, 0);
        run(16'h8001, 12, 16'h5A5A, 1'b0, 0, 0);
        // R8: start pulses while running are ignored
        run(16'hBEEF, 5, model_sig(16'hBEEF, 5, 1'b0, 0), 1'b0, 0, 3);
        run(16'h0F0F, 4, 16'h0, 1'b0, 0, 30);
        // R10: stuck-at-0 changes the result against the clean golden value
        clean  = model_sig(16'hC0DE, 20, 1'b0, 0);
        faulty = model_sig(16'hC0DE, 20, 1'b1, 9);
        run(16'hC0DE, 20, clean, 1'b1, 9, 0);
        if (faulty != clean) check("R10 fault flips verdict", {31'b0, pass_o}, 32'd0);
        run(16'hC0DE, 20, clean, 1'b0, 0, 0);
        check("R10 clean run passes", {31'b0, pass_o}, 32'd1);

        // random runs
        for (int t = 0; t < 24; t++) begin
            logic [15:0] s, g;
            int n, fi;
            bit fe, good;
            s  = 16'($urandom);
            n  = $urandom_range(0, 40);
            fe = ($urandom % 3) == 0;
            fi = $urandom_range(0, 31);
            good = ($urandom % 2) == 0;
            g = good ? model_sig(s, n, fe, fi) : 16'($urandom);
            run(s, n, g, fe, fi, (t % 4 == 0) ? $urandom_range(1, 8) : 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule